// File: doc/BRIEF.md
# Masked Prefix Popcount Unit

The unit turns a short bit vector of up to eight elements into a vector of running counts. Output element i holds the number of qualifying source bits at positions strictly below i. It is used where each lane needs its rank among the enabled lanes before it, for example to compact or scatter elements. The source bits come from one of three places: a plain bit vector, a constant all-ones pattern that gives the index sequence 0..VL-1, or a per-element condition test. The condition test reads a 4-bit field per element, picks one bit of it with a 2-bit select, and passes when that bit equals a compare bit.

A predicate mask and an active length qualify the count. In merge mode a masked-off element keeps the value from a previous destination vector supplied on a port, and its source bit is not counted. In reset mode a masked-off element also keeps its previous value, but the running count starts again from zero after it. A one-cycle `start` pulse launches an operation. One clock later `done` pulses for a single cycle and the new counts appear; they stay unchanged until the next start.

Top module: `prefix_count_unit`

## Requirements
- R1: With mask disabled and VL=8, source 10010001 (element 7 down to 0) gives counts 2,2,2,1,1,1,1,0 for elements 7 down to 0. Each element counts only the set bits strictly below it. Element i of `counts` and `prev_dest` sits in bits [4i+3:4i].
- R2: With `src_use`=0 and `cond_use`=0 the source is all ones, so the active elements read 0,1,...,VL-1.
- R3: With `mask_use`=0 the mask is taken as all ones, whatever `mask_bits` holds.
- R4: In merge mode (`mode_reset`=0) with mask 11101011, source 10010001 and previous destination 2,3,4,5,6,7,8,9 (elements 7 down to 0), the result is 1,1,1,5,1,7,1,0. A masked-off element keeps its previous value and its source bit is not counted.
- R5: In reset mode (`mode_reset`=1) a masked-off active element keeps its previous value, and the running count restarts at zero for the elements after it.
- R6: In reset mode an active, enabled element receives the current count before its own test bit is added.
- R7: With `cond_use`=1 the test bit of element i is bit `fld_sel` of `cond_fields[4i+3:4i]`. It passes when that bit equals `fld_want`. Condition mode takes priority over `src_use` and `src_bits`.
- R8: Elements at index VL or above keep their `prev_dest` value under the default tail parameter. VL=0 leaves every element at its previous value.
- R9: `done` is high exactly in the cycle after a cycle where `start` was high. `counts` change only on that edge and hold otherwise.
- R10: During reset and right after it, `done` is 0 and all counts are 0.
- R11: A `vlen` above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch an operation with the current inputs |
| vlen | input | 4 | Active length, clamped to 8 |
| mode_reset | input | 1 | 0 merge masking, 1 count-restart masking |
| src_use | input | 1 | 1 use `src_bits`, 0 all-ones source |
| src_bits | input | 8 | Plain source bits, element i in bit i |
| cond_use | input | 1 | 1 derive source from condition fields |
| cond_fields | input | 32 | Per-element 4-bit condition fields |
| fld_sel | input | 2 | Bit select inside each condition field |
| fld_want | input | 1 | Value the selected bit must equal to pass |
| mask_use | input | 1 | 1 apply `mask_bits`, 0 all elements enabled |
| mask_bits | input | 8 | Predicate mask, element i in bit i |
| prev_dest | input | 32 | Previous destination counts, 4 bits per element |
| done | output | 1 | One-cycle completion pulse |
| counts | output | 32 | Result counts, 4 bits per element |

## Verification
On every cycle, the assertions check several properties. Counts must hold whenever no start preceded the edge. Element 0 must read zero whenever it was written. Each merge-path count must stay no larger than its index. A reset-mode element that follows a masked-off element must start from zero. Tail elements must keep their previous value. The exact values under each mode need the bench's directed scenarios: the published merge example, the reset-mode restart pattern, the condition-field select and compare polarity, and the clamping of VL. Those scenarios also cover the precedence of condition mode over the plain source.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic {
    MODE_MERGE = 1'b0,
    MODE_RESET = 1'b1
  } pcu_mode_e;

endpackage

// File: rtl/pcu_src_select.sv
module pcu_src_select #(
  parameter int N  = 8,
  parameter int FW = 4,
  parameter int SW = 2
) (
  input  logic [N-1:0]    src_bits,
  input  logic            src_use,
  input  logic            cond_use,
  input  logic [N*FW-1:0] cond_fields,
  input  logic [SW-1:0]   fld_sel,
  input  logic            fld_want,
  output logic [N-1:0]    test_bits
);

  // One condition comparator per element; condition mode wins over the plain source.
  for (genvar gi = 0; gi < N; gi++) begin : g_elem
    logic [FW-1:0] field;
    logic          cond_hit;
    assign field    = cond_fields[gi*FW +: FW];
    assign cond_hit = (field[fld_sel] == fld_want);
    assign test_bits[gi] = cond_use ? cond_hit : (src_use ? src_bits[gi] : 1'b1);
  end

endmodule

// File: rtl/pcu_prefix_merge.sv
module pcu_prefix_merge #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         test_bits,
  input  logic [N-1:0]         en_bits,
  output logic [N-1:0][CW-1:0] cnt
);

  logic [CW-1:0] acc;

  // Exclusive prefix count of enabled test bits.
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      cnt[i] = acc;
      acc    = acc + {{(CW-1){1'b0}}, (test_bits[i] & en_bits[i])};
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_bound
    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[gi] <= CW'(gi));
  end

endmodule

// File: rtl/pcu_prefix_reset.sv
module pcu_prefix_reset #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         test_bits,
  input  logic [N-1:0]         mask_bits,
  input  logic [N-1:0]         act_bits,
  output logic [N-1:0][CW-1:0] cnt
);

  logic [CW-1:0] acc;

  // Segmented count: a masked-off active element clears the running count.
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      cnt[i] = acc;
      if (act_bits[i] && mask_bits[i]) begin
        acc = acc + {{(CW-1){1'b0}}, test_bits[i]};
      end else if (act_bits[i]) begin
        acc    = '0;
        cnt[i] = '0;
      end
    end
  end

  for (genvar gi = 1; gi < N; gi++) begin : g_restart
    // R5
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_bits[gi] && mask_bits[gi] && act_bits[gi-1] && !mask_bits[gi-1])
        |-> (cnt[gi] == '0));
  end

endmodule

// File: rtl/prefix_count_unit.sv
module prefix_count_unit
  import pcu_pkg::*;
#(
  parameter int N         = 8,
  parameter int FW        = 4,
  parameter bit TAIL_ZERO = 1'b0,
  localparam int CW   = $clog2(N + 1),
  localparam int VL_W = $clog2(N + 1),
  localparam int SW   = $clog2(FW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vlen,
  input  logic            mode_reset,
  input  logic            src_use,
  input  logic [N-1:0]    src_bits,
  input  logic            cond_use,
  input  logic [N*FW-1:0] cond_fields,
  input  logic [SW-1:0]   fld_sel,
  input  logic            fld_want,
  input  logic            mask_use,
  input  logic [N-1:0]    mask_bits,
  input  logic [N*CW-1:0] prev_dest,
  output logic            done,
  output logic [N*CW-1:0] counts
);

  // Reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Operand qualification
  pcu_mode_e      mode_sel;
  logic [VL_W-1:0] vl_eff;
  logic [N-1:0]    act_bits;
  logic [N-1:0]    mask_eff;
  logic [N-1:0]    wr_bits;
  logic [N-1:0]    test_bits;

  assign mode_sel = pcu_mode_e'(mode_reset);
  assign vl_eff   = (vlen > VL_W'(N)) ? VL_W'(N) : vlen;
  assign mask_eff = mask_use ? mask_bits : {N{1'b1}};

  for (genvar gi = 0; gi < N; gi++) begin : g_act
    assign act_bits[gi] = (VL_W'(gi) < vl_eff);
  end
  assign wr_bits = act_bits & mask_eff;

  pcu_src_select #(.N(N), .FW(FW), .SW(SW)) u_src (
    .src_bits    (src_bits),
    .src_use     (src_use),
    .cond_use    (cond_use),
    .cond_fields (cond_fields),
    .fld_sel     (fld_sel),
    .fld_want    (fld_want),
    .test_bits   (test_bits)
  );

  logic [N-1:0][CW-1:0] merge_cnt;
  logic [N-1:0][CW-1:0] reset_cnt;

  pcu_prefix_merge #(.N(N), .CW(CW)) u_merge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .test_bits (test_bits),
    .en_bits   (wr_bits),
    .cnt       (merge_cnt)
  );

  pcu_prefix_reset #(.N(N), .CW(CW)) u_reset (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .test_bits (test_bits),
    .mask_bits (mask_eff),
    .act_bits  (act_bits),
    .cnt       (reset_cnt)
  );

  // Next-state selection per element
  logic [N*CW-1:0] counts_d;
  logic [N*CW-1:0] counts_q;
  logic            done_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_next
    logic [CW-1:0] prev_e;
    logic [CW-1:0] tail_e;
    assign prev_e = prev_dest[gi*CW +: CW];
    if (TAIL_ZERO) begin : g_tail_zero
      assign tail_e = '0;
    end else begin : g_tail_keep
      assign tail_e = prev_e;
    end
    always_comb begin
      if (wr_bits[gi]) begin
        counts_d[gi*CW +: CW] = (mode_sel == MODE_RESET) ? reset_cnt[gi] : merge_cnt[gi];
      end else if (act_bits[gi]) begin
        counts_d[gi*CW +: CW] = prev_e;
      end else begin
        counts_d[gi*CW +: CW] = tail_e;
      end
    end
  end

  // Registers with explicit enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      counts_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= start;
      if (start) counts_q <= counts_d;
    end
  end

  assign done   = done_q;
  assign counts = counts_q;

  // R9
  counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(start) |-> (counts == $past(counts)));

  // R1
  first_elem_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && $past(wr_bits[0])) |-> (counts[CW-1:0] == '0));

  if (!TAIL_ZERO) begin : g_tail_chk
    for (genvar gi = 0; gi < N; gi++) begin : g_e
      // R8
      tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (done && $past(!act_bits[gi])) |->
          (counts[gi*CW +: CW] == $past(prev_dest[gi*CW +: CW])));
    end
  end

endmodule

// File: tb/sim_prefix_count_unit.sv
`timescale 1ns/1ps
module sim_prefix_count_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  vlen;
  logic        mode_reset;
  logic        src_use;
  logic [7:0]  src_bits;
  logic        cond_use;
  logic [31:0] cond_fields;
  logic [1:0]  fld_sel;
  logic        fld_want;
  logic        mask_use;
  logic [7:0]  mask_bits;
  logic [31:0] prev_dest;
  logic        done;
  logic [31:0] counts;

  int n_checks;
  int n_fail;

  prefix_count_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .mode_reset(mode_reset), .src_use(src_use), .src_bits(src_bits),
    .cond_use(cond_use), .cond_fields(cond_fields), .fld_sel(fld_sel),
    .fld_want(fld_want), .mask_use(mask_use), .mask_bits(mask_bits),
    .prev_dest(prev_dest), .done(done), .counts(counts)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    start = 1'b0; vlen = 4'd8; mode_reset = 1'b0; src_use = 1'b1;
    src_bits = 8'h00; cond_use = 1'b0; cond_fields = 32'h0; fld_sel = 2'd0;
    fld_want = 1'b0; mask_use = 1'b0; mask_bits = 8'h00; prev_dest = 32'h0;
  endtask

  // Pulse start at a negedge; result is checked at the following negedge.
  task automatic fire();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R10 done after reset", {31'b0, done}, 32'h0);
    chk("R10 counts after reset", counts, 32'h0);
  endtask

  task automatic t_unmasked();
    @(negedge clk);
    idle_inputs();
    src_bits = 8'b1001_0001; mask_bits = 8'h00; prev_dest = 32'hFFFF_FFFF;
    fire();
    chk("R1 R3 unmasked prefix", counts, 32'h2221_1110);
    chk("R9 done pulse high", {31'b0, done}, 32'h1);
    @(negedge clk);
    chk("R9 done pulse low", {31'b0, done}, 32'h0);
  endtask

  task automatic t_identity();
    @(negedge clk);
    idle_inputs();
    src_use = 1'b0; src_bits = 8'h00;
    fire();
    chk("R2 all-ones source sequence", counts, 32'h7654_3210);
    @(negedge clk);
    vlen = 4'd5; prev_dest = 32'hABCD_EF12;
    fire();
    chk("R8 R2 tail keeps previous", counts, 32'hABC4_3210);
  endtask

  task automatic t_merge();
    @(negedge clk);
    idle_inputs();
    mask_use = 1'b1; mask_bits = 8'b1110_1011;
    src_bits = 8'b1001_0001; prev_dest = 32'h2345_6789;
    fire();
    chk("R4 merge example", counts, 32'h1115_1710);
  endtask

  task automatic t_reset_mode();
    @(negedge clk);
    idle_inputs();
    mode_reset = 1'b1; src_use = 1'b0;
    mask_use = 1'b1; mask_bits = 8'b1110_1011; prev_dest = 32'h9876_5432;
    fire();
    chk("R5 R6 reset-mode restart", counts, 32'h2106_0410);
    @(negedge clk);
    src_use = 1'b1; src_bits = 8'b0000_0001; mask_bits = 8'hFF;
    fire();
    chk("R6 own bit counted after write", counts, 32'h1111_1110);
  endtask

  task automatic t_condition();
    @(negedge clk);
    idle_inputs();
    cond_use = 1'b1; src_use = 1'b1; src_bits = 8'h00;
    cond_fields = 32'h4B4B_4B4B; fld_sel = 2'd2; fld_want = 1'b1;
    fire();
    chk("R7 condition select true", counts, 32'h3322_1100);
    @(negedge clk);
    fld_want = 1'b0;
    fire();
    chk("R7 condition compare zero", counts, 32'h4332_2110);
  endtask

  task automatic t_vlen_edges();
    @(negedge clk);
    idle_inputs();
    src_use = 1'b0; vlen = 4'd12;
    fire();
    chk("R11 vlen clamp", counts, 32'h7654_3210);
    @(negedge clk);
    vlen = 4'd0; prev_dest = 32'h1357_9BDF;
    fire();
    chk("R8 vlen zero keeps all", counts, 32'h1357_9BDF);
    vlen = 4'd8; prev_dest = 32'h0; src_bits = 8'hFF;
    @(negedge clk);
    chk("R9 counts hold without start", counts, 32'h1357_9BDF);
    chk("R9 done stays low", {31'b0, done}, 32'h0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_unmasked();
    t_identity();
    t_merge();
    t_reset_mode();
    t_condition();
    t_vlen_edges();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule